// File: doc/BRIEF.md
# Storage packet command decoder with sense tracking

This block sits behind the transfer engine of an optical-storage drive interface. Once the engine has gathered a 12-byte command packet from the host, it hands the packet over with a single-cycle strobe, together with the byte-count value the host had programmed. The decoder reads the opcode and fields and keeps the drive's sense record and error register up to date. For each packet it gives the engine one of two answers. The first is "start a read of N bytes", sent after the reply words are already in the shared word buffer. The second is "complete with result code".

The block keeps a sticky unit-attention condition after reset. It extracts and validates the fields of a sector read. It clips the allocation lengths of the fixed-content replies: the identify bytes come from a computed ROM and the sense reply comes from the sense record. It also tracks the position after the last sector read. A small generator stands in for the media and produces the sector data. Replies go into the buffer one 16-bit word per cycle. The lower byte of word k is reply byte 2k and the upper byte is reply byte 2k+1.

Top module: `pkt_cmd_decoder`

## Requirements
- R1: After reset, busy is 0, status is 0x00, the error register is 0x00, last_lba is 150 and neither strobe is active.
- R2: After reset, the first packet whose opcode is not request-sense (0x13) completes with result 0x2906, status 0x51 and error register 0x60. That completion clears the condition. A request-sense packet neither triggers it nor clears it.
- R3: Setting result code C writes sense byte 0 = 0xF0, sense byte 2 = C[7:0] and sense byte 8 = C[15:8], and sets the error register to {C[3:0],4'h0}. Any nonzero completion gives status 0x51.
- R4: Test-ready (opcode 0x00) completes with 0x0000 and status 0x50 when media_present is 1. When media_present is 0 it completes with 0x3A02.
- R5: Any opcode other than 0x00, 0x11, 0x13 and 0x30 completes with 0x2005.
- R6: A sector read (opcode 0x30) accepts mode byte 1 values 0x20, 0x24, 0x28 and 0x30. Any other mode completes with 0x2405. Each sector is 2352 bytes in mode 0x30 and 2048 bytes in the other modes.
- R7: For a sector read, the start address is bytes 2..4 and the count is bytes 8..10, both big-endian. The count used for the transfer is clipped to MAX_SECT (4). Data word k is start[15:0] + k.
- R8: After a sector read, sense bytes 5, 6 and 7 hold start[23:16], start[15:8] and start[7:0], and last_lba becomes start plus the unclipped count. last_lba changes only together with a read start.
- R9: Identify (opcode 0x11) takes its offset from byte 2 and its allocation from byte 4. An offset of 32 or more completes with 0x2405. Otherwise the length is min(allocation, 32 - offset) and reply byte j is identify byte offset+j, where identify byte i = {i[4:0],3'b101} XOR 0x3C.
- R10: Request-sense replies with min(byte 4, 10) bytes of the sense record as it stood before the packet. The record then takes the OK result.
- R11: rd_bsize reports the xfer_bsize value sampled in the cycle the packet was accepted.
- R12: Each accepted packet produces exactly one done or start_rd pulse. On start_rd, result is 0, status is 0x58 and the error register is 0. All reply words are written to consecutive addresses from 0 before start_rd.
- R13: A packet strobe that arrives while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet handed over (one cycle) |
| pkt_data | input | 96 | Packet bytes, byte n at bits 8n+7:8n |
| xfer_bsize | input | 16 | Host byte-count value |
| media_present | input | 1 | Media loaded |
| busy | output | 1 | Packet being processed |
| buf_we | output | 1 | Reply word write enable |
| buf_addr | output | ADDR_W (13) | Reply word address |
| buf_wdata | output | 16 | Reply word |
| start_rd | output | 1 | Start-read strobe |
| rd_len | output | LEN_W (14) | Read length in bytes |
| rd_bsize | output | 16 | Block size for the read |
| done | output | 1 | Complete strobe |
| result | output | 16 | Result code |
| status | output | 8 | Status register |
| err_reg | output | 8 | Error register |
| last_lba | output | 24 | Position after last sector read |

## Verification
The assertions assume that pkt_data is meaningful only in the cycle of pkt_valid, that pkt_valid is a single-cycle pulse, and that reset lasts at least one clock edge. The bench keeps to these assumptions: it raises pkt_valid for exactly one cycle per packet and changes xfer_bsize only after the packet has been accepted. It raises a second strobe while busy only on purpose, to exercise the ignore rule, and no other stimulus arrives in a busy window.

// File: rtl/pkt_dec_pkg.sv
package pkt_dec_pkg;
  localparam logic [7:0] OP_TEST  = 8'h00;
  localparam logic [7:0] OP_IDENT = 8'h11;
  localparam logic [7:0] OP_SENSE = 8'h13;
  localparam logic [7:0] OP_READ  = 8'h30;

  localparam logic [7:0] MODE_M1  = 8'h20;
  localparam logic [7:0] MODE_GD  = 8'h24;
  localparam logic [7:0] MODE_XA  = 8'h28;
  localparam logic [7:0] MODE_RAW = 8'h30;

  localparam logic [15:0] RC_OK        = 16'h0000;
  localparam logic [15:0] RC_UNIT_ATTN = 16'h2906;
  localparam logic [15:0] RC_NO_MEDIA  = 16'h3A02;
  localparam logic [15:0] RC_BAD_FIELD = 16'h2405;
  localparam logic [15:0] RC_BAD_OP    = 16'h2005;

  localparam logic [7:0] ST_BUSY  = 8'h80;
  localparam logic [7:0] ST_READY = 8'h50;
  localparam logic [7:0] ST_ERROR = 8'h51;
  localparam logic [7:0] ST_DATA  = 8'h58;

  localparam int ID_BYTES    = 32;
  localparam int SENSE_BYTES = 10;

  typedef enum logic [1:0] {S_IDLE, S_DECODE, S_STREAM} dec_state_e;
  typedef enum logic [1:0] {SRC_ID, SRC_SENSE, SRC_SECT} src_e;
endpackage

// File: rtl/pkt_sense_reg.sv
module pkt_sense_reg import pkt_dec_pkg::*; #(
  parameter int NBYTES = SENSE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_res,
  input  logic [15:0]           res_code,
  input  logic                  set_pos,
  input  logic [23:0]           pos,
  output logic [8*NBYTES-1:0]   sense_flat,
  output logic [7:0]            err_q
);
  logic [7:0] sb [NBYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) sb[i] <= 8'h00;
      err_q <= 8'h00;
    end else begin
      if (set_res) begin
        sb[0] <= 8'hF0;
        sb[2] <= res_code[7:0];
        sb[8] <= res_code[15:8];
        err_q <= {res_code[3:0], 4'h0};
      end
      if (set_pos) begin
        sb[5] <= pos[23:16];
        sb[6] <= pos[15:8];
        sb[7] <= pos[7:0];
      end
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_flat
    assign sense_flat[8*g +: 8] = sb[g];
  end
endmodule

// File: rtl/pkt_word_src.sv
module pkt_word_src import pkt_dec_pkg::*; #(
  parameter int ADDR_W = 13
) (
  input  src_e                      kind,
  input  logic [7:0]                off,
  input  logic [ADDR_W-1:0]         widx,
  input  logic [8*SENSE_BYTES-1:0]  sense_flat,
  input  logic [23:0]               base_lba,
  output logic [15:0]               word
);
  function automatic logic [7:0] id_byte(input logic [15:0] i);
    return (i < 16'(ID_BYTES)) ? ({i[4:0], 3'b101} ^ 8'h3C) : 8'h00;
  endfunction

  function automatic logic [7:0] sn_byte(input logic [15:0] i);
    logic [7:0] b;
    b = 8'h00;
    for (int k = 0; k < SENSE_BYTES; k++)
      if (i == 16'(k)) b = sense_flat[8*k +: 8];
    return b;
  endfunction

  logic [15:0] even_i;
  assign even_i = 16'({widx, 1'b0});

  always_comb begin
    unique case (kind)
      SRC_ID:    word = {id_byte(16'(off) + even_i + 16'd1), id_byte(16'(off) + even_i)};
      SRC_SENSE: word = {sn_byte(even_i + 16'd1), sn_byte(even_i)};
      default:   word = base_lba[15:0] + 16'(widx);
    endcase
  end
endmodule

// File: rtl/pkt_cmd_decoder.sv
module pkt_cmd_decoder import pkt_dec_pkg::*; #(
  parameter int          MAX_SECT     = 4,
  parameter int          COOKED_BYTES = 2048,
  parameter int          RAW_BYTES    = 2352,
  parameter logic [23:0] RESET_LBA    = 24'd150,
  localparam int         LEN_W        = $clog2(MAX_SECT*RAW_BYTES+1),
  localparam int         ADDR_W       = $clog2(MAX_SECT*RAW_BYTES/2+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_valid,
  input  logic [95:0]       pkt_data,
  input  logic [15:0]       xfer_bsize,
  input  logic              media_present,
  output logic              busy,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [15:0]       buf_wdata,
  output logic              start_rd,
  output logic [LEN_W-1:0]  rd_len,
  output logic [15:0]       rd_bsize,
  output logic              done,
  output logic [15:0]       result,
  output logic [7:0]        status,
  output logic [7:0]        err_reg,
  output logic [23:0]       last_lba
);
  dec_state_e state;
  logic [7:0]  op_q, md_q, f2_q, f3_q, f4_q;
  logic [23:0] cnt_q, lba_q, rcnt_q;
  logic [15:0] bsz_q;
  logic        was_rst;
  src_e        kind_q;
  logic [7:0]  off_q;
  logic [LEN_W-1:0]  rlen_q;
  logic [ADDR_W-1:0] nw_q, widx;

  logic unused_pkt_bits;
  assign unused_pkt_bits = ^{pkt_data[63:40], pkt_data[95:88]};

  // field extraction and lengths
  logic [23:0]      lba_f;
  logic             mode_ok;
  logic [LEN_W-1:0] sect_b, cnt_c, sec_len, id_len, sn_len;
  logic [7:0]       avail;

  assign lba_f   = {f2_q, f3_q, f4_q};
  assign mode_ok = (md_q == MODE_M1) || (md_q == MODE_GD) ||
                   (md_q == MODE_XA) || (md_q == MODE_RAW);
  assign sect_b  = (md_q == MODE_RAW) ? LEN_W'(RAW_BYTES) : LEN_W'(COOKED_BYTES);
  assign cnt_c   = (cnt_q > 24'(MAX_SECT)) ? LEN_W'(MAX_SECT) : LEN_W'(cnt_q);
  assign sec_len = LEN_W'(cnt_c * sect_b);
  assign avail   = 8'(ID_BYTES) - f2_q;
  assign id_len  = (f4_q > avail) ? LEN_W'(avail) : LEN_W'(f4_q);
  assign sn_len  = (f4_q > 8'(SENSE_BYTES)) ? LEN_W'(SENSE_BYTES) : LEN_W'(f4_q);

  // decode decision
  logic             cmpl, go_rd, clr_rst;
  logic [15:0]      cmpl_code;
  src_e             go_kind;
  logic [LEN_W-1:0] go_len;

  always_comb begin
    cmpl = 1'b0; go_rd = 1'b0; clr_rst = 1'b0;
    cmpl_code = RC_OK; go_kind = SRC_SECT; go_len = '0;
    if (state == S_DECODE) begin
      if (was_rst && op_q != OP_SENSE) begin
        cmpl = 1'b1; cmpl_code = RC_UNIT_ATTN; clr_rst = 1'b1;
      end else begin
        case (op_q)
          OP_TEST: begin
            cmpl = 1'b1;
            cmpl_code = media_present ? RC_OK : RC_NO_MEDIA;
          end
          OP_IDENT: begin
            if (f2_q >= 8'(ID_BYTES)) begin
              cmpl = 1'b1; cmpl_code = RC_BAD_FIELD;
            end else begin
              go_rd = 1'b1; go_kind = SRC_ID; go_len = id_len;
            end
          end
          OP_SENSE: begin
            go_rd = 1'b1; go_kind = SRC_SENSE; go_len = sn_len;
          end
          OP_READ: begin
            if (mode_ok) begin
              go_rd = 1'b1; go_kind = SRC_SECT; go_len = sec_len;
            end else begin
              cmpl = 1'b1; cmpl_code = RC_BAD_FIELD;
            end
          end
          default: begin
            cmpl = 1'b1; cmpl_code = RC_BAD_OP;
          end
        endcase
      end
    end
  end

  logic fin;
  assign fin = (state == S_STREAM) && (widx == nw_q);

  logic [8*SENSE_BYTES-1:0] sense_flat;
  logic [15:0]              src_word;

  pkt_sense_reg u_sense (
    .clk        (clk),
    .rst        (rst),
    .set_res    (cmpl | fin),
    .res_code   (cmpl ? cmpl_code : RC_OK),
    .set_pos    (fin && kind_q == SRC_SECT),
    .pos        (lba_q),
    .sense_flat (sense_flat),
    .err_q      (err_reg)
  );

  pkt_word_src #(.ADDR_W(ADDR_W)) u_src (
    .kind       (kind_q),
    .off        (off_q),
    .widx       (widx),
    .sense_flat (sense_flat),
    .base_lba   (lba_q),
    .word       (src_word)
  );

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      op_q <= '0; md_q <= '0; f2_q <= '0; f3_q <= '0; f4_q <= '0;
      cnt_q <= '0; bsz_q <= '0; was_rst <= 1'b1;
      kind_q <= SRC_SECT; off_q <= '0; lba_q <= '0; rcnt_q <= '0;
      rlen_q <= '0; nw_q <= '0; widx <= '0;
      buf_we <= 1'b0; buf_addr <= '0; buf_wdata <= '0;
      start_rd <= 1'b0; rd_len <= '0; rd_bsize <= '0;
      done <= 1'b0; result <= '0; status <= 8'h00;
      last_lba <= RESET_LBA;
    end else begin
      done <= 1'b0;
      start_rd <= 1'b0;
      buf_we <= 1'b0;
      unique case (state)
        S_IDLE: if (pkt_valid) begin
          op_q  <= pkt_data[7:0];
          md_q  <= pkt_data[15:8];
          f2_q  <= pkt_data[23:16];
          f3_q  <= pkt_data[31:24];
          f4_q  <= pkt_data[39:32];
          cnt_q <= {pkt_data[71:64], pkt_data[79:72], pkt_data[87:80]};
          bsz_q <= xfer_bsize;
          status <= ST_BUSY;
          state <= S_DECODE;
        end
        S_DECODE: begin
          if (clr_rst) was_rst <= 1'b0;
          if (cmpl) begin
            done   <= 1'b1;
            result <= cmpl_code;
            status <= (cmpl_code == RC_OK) ? ST_READY : ST_ERROR;
            state  <= S_IDLE;
          end else if (go_rd) begin
            kind_q <= go_kind;
            off_q  <= f2_q;
            lba_q  <= lba_f;
            rcnt_q <= cnt_q;
            rlen_q <= go_len;
            nw_q   <= ADDR_W'((32'(go_len) + 32'd1) >> 1);
            widx   <= '0;
            state  <= S_STREAM;
          end else begin
            state  <= S_IDLE;
          end
        end
        S_STREAM: begin
          if (fin) begin
            start_rd <= 1'b1;
            rd_len   <= rlen_q;
            rd_bsize <= bsz_q;
            result   <= RC_OK;
            status   <= ST_DATA;
            if (kind_q == SRC_SECT) last_lba <= lba_q + rcnt_q;
            state    <= S_IDLE;
          end else begin
            buf_we    <= 1'b1;
            buf_addr  <= widx;
            buf_wdata <= src_word;
            widx      <= widx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_dec_chk.sv
module pkt_dec_chk #(
  parameter int ADDR_W = 13,
  parameter int LEN_W  = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              pkt_valid,
  input logic              busy,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              start_rd,
  input logic [LEN_W-1:0]  rd_len,
  input logic              done,
  input logic [15:0]       result,
  input logic [7:0]        status,
  input logic [7:0]        err_reg,
  input logic [23:0]       last_lba
);
  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && start_rd));

  // R12
  start_status_chk: assert property (@(posedge clk) disable iff (rst)
    start_rd |-> (status == 8'h58 && err_reg == 8'h00 && result == 16'h0000));

  // R3
  err_status_chk: assert property (@(posedge clk) disable iff (rst)
    (done && result != 16'h0000) |-> (status == 8'h51 && err_reg == {result[3:0], 4'h0}));

  // R12
  wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> busy);

  // R12
  addr_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we)) |-> (buf_addr == $past(buf_addr) + 1'b1));

  // R8
  lba_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start_rd |-> $stable(last_lba));

  // R13
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !busy) |=> busy);

  // R12
  len_width_chk: assert property (@(posedge clk) disable iff (rst)
    start_rd |-> !busy);
endmodule

bind pkt_cmd_decoder pkt_dec_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .busy(busy), .buf_we(buf_we),
  .buf_addr(buf_addr), .start_rd(start_rd), .rd_len(rd_len), .done(done),
  .result(result), .status(status), .err_reg(err_reg), .last_lba(last_lba)
);

// File: tb/tb_pkt_cmd_decoder.sv
`timescale 1ns/1ps
module tb_pkt_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_valid = 1'b0;
  logic [95:0] pkt_data = '0;
  logic [15:0] xfer_bsize = '0;
  logic        media_present = 1'b1;
  logic        busy, buf_we, start_rd, done;
  logic [12:0] buf_addr;
  logic [15:0] buf_wdata, rd_bsize, result;
  logic [13:0] rd_len;
  logic [7:0]  status, err_reg;
  logic [23:0] last_lba;

  always #4 clk = ~clk;

  pkt_cmd_decoder dut (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .xfer_bsize(xfer_bsize), .media_present(media_present), .busy(busy),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .start_rd(start_rd), .rd_len(rd_len), .rd_bsize(rd_bsize), .done(done),
    .result(result), .status(status), .err_reg(err_reg), .last_lba(last_lba)
  );

  int errors = 0, checks = 0, strobes = 0;
  bit finished = 0;
  logic [15:0] mem [8192];

  always @(negedge clk) begin
    if (buf_we) mem[buf_addr] = buf_wdata;
    if (done || start_rd) strobes++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] id_b(input int i);
    logic [7:0] v;
    v = 8'(i);
    return (i < 32) ? ({v[4:0], 3'b101} ^ 8'h3C) : 8'h00;
  endfunction

  logic        g_rd;
  logic [15:0] g_code, g_bs;
  logic [13:0] g_len;
  logic [7:0]  g_st, g_err;

  task automatic send(input logic [7:0] op, b1, b2, b3, b4, input logic [23:0] cnt,
                      input logic [15:0] bs);
    @(negedge clk);
    pkt_data = '0;
    pkt_data[7:0] = op;   pkt_data[15:8] = b1;  pkt_data[23:16] = b2;
    pkt_data[31:24] = b3; pkt_data[39:32] = b4;
    pkt_data[71:64] = cnt[23:16]; pkt_data[79:72] = cnt[15:8]; pkt_data[87:80] = cnt[7:0];
    xfer_bsize = bs;
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    xfer_bsize = 16'hFFFF;
  endtask

  task automatic wait_strobe();
    bit seen = 0;
    for (int n = 0; n < 20000 && !seen; n++) begin
      @(negedge clk);
      if (done || start_rd) begin
        seen = 1;
        g_rd = start_rd; g_code = result; g_len = rd_len; g_bs = rd_bsize;
        g_st = status; g_err = err_reg;
      end
    end
    if (!seen) chk("R12 strobe missing", 0, 1);
  endtask

  task automatic run(input logic [7:0] op, b1, b2, b3, b4, input logic [23:0] cnt,
                     input logic [15:0] bs);
    int s0;
    s0 = strobes;
    send(op, b1, b2, b3, b4, cnt, bs);
    wait_strobe();
    repeat (3) @(negedge clk);
    chk("R12 single strobe", strobes - s0, 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  typedef struct packed {
    logic        media;
    logic [7:0]  op, b1, b2, b3, b4;
    logic [23:0] cnt;
    logic        is_rd;
    logic [15:0] code;
    logic [15:0] len;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 24'd0, 1'b0, 16'h2906, 16'd0},    // R2
    '{1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 24'd0, 1'b0, 16'h0000, 16'd0},    // R4
    '{1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 24'd0, 1'b0, 16'h3A02, 16'd0},    // R4
    '{1'b1, 8'h55, 8'h00, 8'h00, 8'h00, 8'h00, 24'd0, 1'b0, 16'h2005, 16'd0},    // R5
    '{1'b1, 8'h30, 8'h22, 8'h00, 8'h00, 8'h00, 24'd1, 1'b0, 16'h2405, 16'd0},    // R6
    '{1'b1, 8'h11, 8'h00, 8'h28, 8'h00, 8'h20, 24'd0, 1'b0, 16'h2405, 16'd0},    // R9
    '{1'b1, 8'h11, 8'h00, 8'h00, 8'h00, 8'h20, 24'd0, 1'b1, 16'h0000, 16'd32},   // R9
    '{1'b1, 8'h11, 8'h00, 8'h14, 8'h00, 8'h1E, 24'd0, 1'b1, 16'h0000, 16'd12},   // R9
    '{1'b1, 8'h30, 8'h24, 8'h00, 8'h01, 8'h23, 24'd1, 1'b1, 16'h0000, 16'd2048}, // R6
    '{1'b1, 8'h30, 8'h30, 8'h00, 8'h00, 8'h40, 24'd1, 1'b1, 16'h0000, 16'd2352}, // R6
    '{1'b1, 8'h30, 8'h20, 8'h0F, 8'hFF, 8'hFF, 24'd6, 1'b1, 16'h0000, 16'd8192}, // R7
    '{1'b1, 8'h13, 8'h00, 8'h00, 8'h00, 8'h14, 24'd0, 1'b1, 16'h0000, 16'd10},   // R10
    '{1'b1, 8'h30, 8'h28, 8'h00, 8'h00, 8'h10, 24'd2, 1'b1, 16'h0000, 16'd4096}  // R6
  };

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 status", status, 8'h00);
    chk("R1 err", err_reg, 8'h00);
    chk("R1 last_lba", last_lba, 24'd150);
    chk("R1 strobes", {done, start_rd}, 2'b00);

    for (int i = 0; i < 13; i++) begin
      vec_t v;
      v = VECS[i];
      media_present = v.media;
      run(v.op, v.b1, v.b2, v.b3, v.b4, v.cnt, 16'h0100 + 16'(i));
      chk($sformatf("R12 vec%0d kind", i), g_rd, v.is_rd);
      chk($sformatf("R3 vec%0d code", i), g_code, v.code);
      if (v.is_rd) begin
        chk($sformatf("R7 vec%0d len", i), g_len, v.len);
        chk($sformatf("R11 vec%0d bsize", i), g_bs, 16'h0100 + 16'(i));
        chk($sformatf("R12 vec%0d status", i), g_st, 8'h58);
        chk($sformatf("R12 vec%0d err", i), g_err, 8'h00);
      end else begin
        chk($sformatf("R3 vec%0d status", i), g_st, (v.code == 0) ? 8'h50 : 8'h51);
        chk($sformatf("R3 vec%0d err", i), g_err, {v.code[3:0], 4'h0});
      end
    end
    media_present = 1'b1;
    chk("R8 last_lba after 2-sector read", last_lba, 24'h000012);

    // R8 sense position bytes via request-sense
    run(8'h13, 0, 0, 0, 8'h0A, 0, 16'h0);
    chk("R8 sense bytes 6,7", mem[3], 16'h1000);
    chk("R3 sense byte 0", mem[0], 16'h00F0);

    // R3 sense after bad opcode
    run(8'h77, 0, 0, 0, 0, 0, 16'h0);
    run(8'h13, 0, 0, 0, 8'h0A, 0, 16'h0);
    chk("R3 sense bytes 2,3", mem[1], 16'h0005);
    chk("R3 sense bytes 8,9", mem[4], 16'h0020);
    // R10 previous request-sense set OK
    run(8'h13, 0, 0, 0, 8'h0A, 0, 16'h0);
    chk("R10 sense cleared to OK", mem[4], 16'h0000);

    // R9 identify data
    run(8'h11, 0, 8'h14, 0, 8'h1E, 0, 16'h0);
    chk("R9 id word0", mem[0], {id_b(21), id_b(20)});
    chk("R9 id word5", mem[5], {id_b(31), id_b(30)});

    // R7 sector stub data and R8 position
    run(8'h30, 8'h24, 8'h00, 8'h01, 8'h23, 24'd1, 16'h0040);
    chk("R7 sector word0", mem[0], 16'h0123);
    chk("R7 sector last word", mem[1023], 16'h0522);
    chk("R8 last_lba", last_lba, 24'h000124);
    chk("R11 bsize latched", g_bs, 16'h0040);

    // R13 packet during busy ignored
    begin
      int s0;
      s0 = strobes;
      send(8'h30, 8'h20, 8'h00, 8'h02, 8'h00, 24'd1, 16'h0);
      repeat (10) @(negedge clk);
      pkt_data = '0; pkt_data[7:0] = 8'h55; pkt_valid = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0;
      wait_strobe();
      repeat (60) @(negedge clk);
      chk("R13 only one strobe", strobes - s0, 1);
      chk("R13 read completed", g_rd, 1);
      chk("R13 last_lba", last_lba, 24'h000201);
    end

    // R2 request-sense does not clear unit attention
    do_reset();
    run(8'h13, 0, 0, 0, 8'h0A, 0, 16'h0);
    chk("R2 sense passes", g_rd, 1);
    chk("R2 sense after reset zero", mem[0], 16'h0000);
    run(8'h11, 0, 0, 0, 8'h04, 0, 16'h0);
    chk("R2 still pending", g_code, 16'h2906);
    chk("R2 err reg", g_err, 8'h60);
    run(8'h11, 0, 0, 0, 8'h04, 0, 16'h0);
    chk("R2 cleared", g_len, 14'd4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule